// File: doc/BRIEF.md
# Eight-Level Nested Interrupt Controller

This block collects up to eight level-sensitive interrupt request lines and tells a processor when one of them needs service. Requests are sampled into a request register each clock and filtered by a per-level mask. An in-service register records which levels are being handled. The interrupt output rises only when an unmasked request ranks strictly above every level already in service. Level 0 ranks highest and level 7 ranks lowest, and the order is fixed.

The processor answers with two acknowledge pulses on `inta`. A state machine follows them through the states IDLE, PULSE1, GAP and PULSE2:
- IDLE→PULSE1 happens when `inta` is seen high. On that edge the winning level is latched and its in-service bit is set.
- PULSE1→GAP happens when `inta` goes low.
- GAP→PULSE2 happens when `inta` rises again. In PULSE2 the vector is driven.
- PULSE2→IDLE happens when `inta` falls. If automatic end-of-interrupt is enabled, the highest in-service bit is released on this transition.

Software ends service with a command write. A command can clear the highest in-service level, or it can clear a level it names. A special-mask option keeps a non-specific command from clearing in-service levels that are masked.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `vec_out` are 0. The reset state also has all levels unmasked, the vector base at 0, both mode bits off and no level in service.
- R2: `int_out` is 1 when a request is held with its mask bit clear and no level is in service. A request whose mask bit is set does not raise `int_out`.
- R3: While a level is in service, requests at that level or a lower-ranked level (larger index) keep `int_out` at 0. A request at a strictly higher-ranked level (smaller index) still raises it.
- R4: During the first acknowledge pulse `vec_valid` is 0 and `vec_out` is 0. During the second pulse `vec_valid` is 1. In that pulse `vec_out` equals `{base_din as last written, 3-bit level}`, so bits 7:3 hold the base and bits 2:0 hold the level. A second pulse only follows a low gap after the first.
- R5: On the rising edge of the first pulse, the lowest-indexed pending unmasked request that outranks all in-service levels is chosen, and its in-service bit is set.
- R6: If no request qualifies when the first pulse starts, the vector carries level 7 and no in-service bit is set.
- R7: A command with `cmd_eoi`=1, `cmd_sl`=0 and `cmd_rot`=0 (non-specific) clears exactly one in-service bit, the highest-ranked one that is set.
- R8: A command with `cmd_eoi`=1, `cmd_sl`=1 and `cmd_rot`=0 (specific) clears the in-service bit at level `cmd_lvl`.
- R9: A command with `cmd_rot`=1 or `cmd_eoi`=0 has no effect on the in-service register.
- R10: When special mask mode is on (`cfg_smm`=1 latched by `cfg_wr`), a non-specific command skips in-service bits whose mask bit is set. It clears the highest-ranked unmasked in-service bit instead.
- R11: When automatic end-of-interrupt is on (`cfg_auto_eoi`=1 latched by `cfg_wr`), the falling edge of the second pulse performs a non-specific clear. As a result, no in-service bit remains from that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Level-sensitive request lines, bit n is level n |
| mask_wr | input | 1 | Load mask register |
| mask_din | input | 8 | Mask value, 1 blocks the level |
| base_wr | input | 1 | Load vector base |
| base_din | input | 5 | Upper five vector bits |
| cfg_wr | input | 1 | Load mode bits |
| cfg_auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| cfg_smm | input | 1 | Special mask mode enable |
| cmd_wr | input | 1 | Command write strobe |
| cmd_eoi | input | 1 | End-of-interrupt bit of the command |
| cmd_sl | input | 1 | Selects specific (1) or non-specific (0) |
| cmd_rot | input | 1 | Rotate bit; when set the command is ignored |
| cmd_lvl | input | 3 | Level for a specific command |
| inta | input | 1 | Acknowledge pulse, active high |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid in the second pulse |
| vec_valid | output | 1 | High while the second pulse is active |

## Verification
The bench sets up two nested levels and then issues non-specific commands one at a time. A design that cleared the lowest-ranked bit, or all bits, would let a request through at the wrong step. It acknowledges with no request pending, so a design that marked level 7 in service would then block a later level-7 request. Under special mask mode, clearing the masked top level would let a level-1 request through too early. Reserved command encodings are sent while a request is held blocked, and a design that decoded them would raise the interrupt.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_P1    = 2'd1,
        ACK_GAP   = 2'd2,
        ACK_P2    = 2'd3
    } ack_state_e;

    typedef enum logic [1:0] {
        EOI_NONE    = 2'd0,
        EOI_NONSPEC = 2'd1,
        EOI_SPEC    = 2'd2
    } eoi_kind_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority resolver: lowest set index wins; returns N-1 when empty.
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          hit
);
    always_comb begin
        hit = |req;
        idx = IW'(N - 1);
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_nest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inta,
    output logic ack_start,
    output logic ack_end,
    output logic in_p2
);
    ack_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: if (inta)  state_d = ACK_P1;
            ACK_P1:   if (!inta) state_d = ACK_GAP;
            ACK_GAP:  if (inta)  state_d = ACK_P2;
            ACK_P2:   if (!inta) state_d = ACK_IDLE;
        endcase
    end

    always_comb begin
        ack_start = 1'b0;
        ack_end   = 1'b0;
        in_p2     = 1'b0;
        unique case (state_q)
            ACK_IDLE: ack_start = inta;
            ACK_P1:   ;
            ACK_GAP:  ;
            ACK_P2: begin
                in_p2   = 1'b1;
                ack_end = !inta;
            end
        endcase
    end

    // R4: the second pulse is only entered from the gap
    p_second_pulse_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_P2 && $past(state_q) != ACK_P2) |-> $past(state_q) == ACK_GAP);

endmodule

// File: rtl/irq_eoi_decode.sv
module irq_eoi_decode
    import irq_nest_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          cmd_wr,
    input  logic          cmd_eoi,
    input  logic          cmd_sl,
    input  logic          cmd_rot,
    input  logic [IW-1:0] cmd_lvl,
    input  logic          auto_fire,
    input  logic          smm_en,
    input  logic [N-1:0]  isr,
    input  logic [N-1:0]  imr,
    output logic [N-1:0]  clr
);
    logic [N-1:0]  elig;
    logic [IW-1:0] ns_idx;
    logic          ns_hit;
    eoi_kind_e     kind;

    assign elig = smm_en ? (isr & ~imr) : isr;

    irq_prio_pick #(.N(N), .IW(IW)) u_ns_pick (
        .req (elig),
        .idx (ns_idx),
        .hit (ns_hit)
    );

    always_comb begin
        if (cmd_wr && cmd_eoi && !cmd_rot) kind = cmd_sl ? EOI_SPEC : EOI_NONSPEC;
        else                               kind = EOI_NONE;
    end

    always_comb begin
        clr = '0;
        unique case (kind)
            EOI_SPEC:    clr = N'(1) << cmd_lvl;
            EOI_NONSPEC: if (ns_hit) clr = N'(1) << ns_idx;
            default:     clr = '0;
        endcase
        if (auto_fire && ns_hit) clr = clr | (N'(1) << ns_idx);
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    localparam int IW   = $clog2(N),
    localparam int BW   = VEC_W - IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          mask_wr,
    input  logic [N-1:0]  mask_din,
    input  logic          base_wr,
    input  logic [BW-1:0] base_din,
    input  logic          cfg_wr,
    input  logic          cfg_auto_eoi,
    input  logic          cfg_smm,
    input  logic          cmd_wr,
    input  logic          cmd_eoi,
    input  logic          cmd_sl,
    input  logic          cmd_rot,
    input  logic [IW-1:0] cmd_lvl,
    input  logic          inta,
    output logic          int_out,
    output logic [VEC_W-1:0] vec_out,
    output logic          vec_valid
);
    logic [N-1:0]  irr_q, imr_q, isr_q;
    logic [BW-1:0] base_q;
    logic          auto_q, smm_q;
    logic [IW-1:0] lvl_q;

    logic [IW-1:0] p_idx, s_idx;
    logic          p_hit, s_hit;
    logic          int_req;
    logic          ack_start, ack_end, in_p2, auto_fire;
    logic [N-1:0]  win_oh, clr;

    irq_prio_pick #(.N(N), .IW(IW)) u_pend_pick (
        .req (irr_q & ~imr_q),
        .idx (p_idx),
        .hit (p_hit)
    );

    irq_prio_pick #(.N(N), .IW(IW)) u_serv_pick (
        .req (isr_q),
        .idx (s_idx),
        .hit (s_hit)
    );

    irq_ack_fsm u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .inta      (inta),
        .ack_start (ack_start),
        .ack_end   (ack_end),
        .in_p2     (in_p2)
    );

    assign auto_fire = ack_end && auto_q;

    irq_eoi_decode #(.N(N), .IW(IW)) u_eoi (
        .cmd_wr    (cmd_wr),
        .cmd_eoi   (cmd_eoi),
        .cmd_sl    (cmd_sl),
        .cmd_rot   (cmd_rot),
        .cmd_lvl   (cmd_lvl),
        .auto_fire (auto_fire),
        .smm_en    (smm_q),
        .isr       (isr_q),
        .imr       (imr_q),
        .clr       (clr)
    );

    assign int_req = p_hit && (!s_hit || (p_idx < s_idx));
    assign int_out = int_req;
    assign win_oh  = (ack_start && int_req) ? (N'(1) << p_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            imr_q  <= '0;
            isr_q  <= '0;
            base_q <= '0;
            auto_q <= 1'b0;
            smm_q  <= 1'b0;
            lvl_q  <= '0;
        end else begin
            irr_q <= irq_in & ~win_oh;
            isr_q <= (isr_q | win_oh) & ~clr;
            if (mask_wr) imr_q  <= mask_din;
            if (base_wr) base_q <= base_din;
            if (cfg_wr) begin
                auto_q <= cfg_auto_eoi;
                smm_q  <= cfg_smm;
            end
            if (ack_start) lvl_q <= int_req ? p_idx : IW'(N - 1);
        end
    end

    always_comb begin
        vec_valid = in_p2;
        vec_out   = in_p2 ? {base_q, lvl_q} : '0;
    end

    // R5: the chosen level is in service one cycle after the first pulse starts
    p_isr_set_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && int_req && !cmd_wr) |=> (isr_q & $past(win_oh)) != '0);

    // R3: nothing outranks level 0 once it is in service
    p_top_level_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q[0] |-> !int_out);

    // R9: reserved command encodings leave the in-service register untouched
    p_ignored_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (cmd_rot || !cmd_eoi) && !ack_start && !auto_fire) |=> $stable(isr_q));

    // R7: a non-specific command removes at most one bit and adds none
    p_nonspec_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_eoi && !cmd_sl && !cmd_rot && !ack_start && !auto_fire)
        |=> (($countones(isr_q) + 1 >= $countones($past(isr_q)))
             && ((isr_q & ~$past(isr_q)) == '0)));

    // R11: automatic mode releases a level at the end of the second pulse
    p_auto_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_end && auto_q && !smm_q && (isr_q != '0))
        |=> $countones(isr_q) < $countones($past(isr_q)));

endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       mask_wr;
    logic [7:0] mask_din;
    logic       base_wr;
    logic [4:0] base_din;
    logic       cfg_wr, cfg_auto_eoi, cfg_smm;
    logic       cmd_wr, cmd_eoi, cmd_sl, cmd_rot;
    logic [2:0] cmd_lvl;
    logic       inta;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .mask_wr(mask_wr), .mask_din(mask_din),
        .base_wr(base_wr), .base_din(base_din),
        .cfg_wr(cfg_wr), .cfg_auto_eoi(cfg_auto_eoi), .cfg_smm(cfg_smm),
        .cmd_wr(cmd_wr), .cmd_eoi(cmd_eoi), .cmd_sl(cmd_sl), .cmd_rot(cmd_rot),
        .cmd_lvl(cmd_lvl), .inta(inta),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk) irq_in = v;
        @(negedge clk);
    endtask

    task automatic set_mask(input logic [7:0] v);
        @(negedge clk) begin mask_wr = 1'b1; mask_din = v; end
        @(negedge clk) mask_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic ae, input logic sm);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_auto_eoi = ae; cfg_smm = sm; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic send_cmd(input logic rot, input logic sl, input logic eoi, input logic [2:0] lvl);
        @(negedge clk) begin
            cmd_wr = 1'b1; cmd_rot = rot; cmd_sl = sl; cmd_eoi = eoi; cmd_lvl = lvl;
        end
        @(negedge clk) cmd_wr = 1'b0;
    endtask

    // R4: two pulses; first returns nothing, second returns the vector
    task automatic do_ack(output logic [7:0] vec);
        @(negedge clk) inta = 1'b1;
        @(negedge clk) begin
            chk(vec_valid == 1'b0 && vec_out == 8'h00, "R4 first pulse", vec_out, 0);
            inta = 1'b0;
        end
        @(negedge clk) inta = 1'b1;
        @(negedge clk) begin
            chk(vec_valid == 1'b1, "R4 second pulse valid", vec_valid, 1);
            vec  = vec_out;
            inta = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(int_out == 1'b0, "R1 int_out", int_out, 0);
        chk(vec_valid == 1'b0 && vec_out == 8'h00, "R1 vector", vec_out, 0);
    endtask

    task automatic t_raise_mask;
        set_irq(8'h10);
        chk(int_out == 1'b1, "R2 unmasked raises", int_out, 1);
        set_mask(8'h10);
        chk(int_out == 1'b0, "R2 masked blocked", int_out, 0);
        set_mask(8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_ack_nest;
        logic [7:0] v;
        @(negedge clk) begin base_wr = 1'b1; base_din = 5'b10101; end
        @(negedge clk) base_wr = 1'b0;
        set_irq(8'h24);
        do_ack(v);
        chk(v == 8'hAA, "R5 R4 winner level 2", v, 8'hAA);
        @(negedge clk);
        chk(int_out == 1'b0, "R3 same and lower blocked", int_out, 0);
        set_irq(8'h26);
        chk(int_out == 1'b1, "R3 higher passes", int_out, 1);
        set_irq(8'h04);
        chk(int_out == 1'b0, "R3 level 2 still blocked", int_out, 0);
        send_cmd(1'b0, 1'b1, 1'b1, 3'd2);
        chk(int_out == 1'b1, "R8 specific clears level 2", int_out, 1);
        set_irq(8'h00);
    endtask

    task automatic t_no_request;
        logic [7:0] v;
        do_ack(v);
        chk(v == 8'hAF, "R6 empty gives level 7", v, 8'hAF);
        set_irq(8'h80);
        chk(int_out == 1'b1, "R6 level 7 not in service", int_out, 1);
        set_irq(8'h00);
    endtask

    task automatic t_nonspec;
        logic [7:0] v;
        set_irq(8'h08);
        do_ack(v);
        chk(v == 8'hAB, "R5 level 3", v, 8'hAB);
        set_irq(8'h02);
        do_ack(v);
        chk(v == 8'hA9, "R5 nested level 1", v, 8'hA9);
        set_irq(8'h04);
        chk(int_out == 1'b0, "R3 level 2 under level 1", int_out, 0);
        send_cmd(1'b0, 1'b0, 1'b1, 3'd0);
        chk(int_out == 1'b1, "R7 top level cleared", int_out, 1);
        set_irq(8'h20);
        chk(int_out == 1'b0, "R7 level 3 kept", int_out, 0);
        send_cmd(1'b0, 1'b0, 1'b1, 3'd0);
        chk(int_out == 1'b1, "R7 second clear", int_out, 1);
        set_irq(8'h00);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        set_irq(8'h01);
        do_ack(v);
        @(negedge clk);
        chk(int_out == 1'b0, "R9 level 0 in service", int_out, 0);
        send_cmd(1'b1, 1'b0, 1'b1, 3'd0);
        chk(int_out == 1'b0, "R9 rotate bit ignored", int_out, 0);
        send_cmd(1'b0, 1'b1, 1'b0, 3'd0);
        chk(int_out == 1'b0, "R9 eoi clear ignored", int_out, 0);
        send_cmd(1'b0, 1'b1, 1'b1, 3'd0);
        chk(int_out == 1'b1, "R8 specific level 0", int_out, 1);
        set_irq(8'h00);
    endtask

    task automatic t_smm;
        logic [7:0] v;
        set_cfg(1'b0, 1'b1);
        set_irq(8'h10);
        do_ack(v);
        set_irq(8'h01);
        do_ack(v);
        chk(v == 8'hA8, "R5 level 0 over 4", v, 8'hA8);
        set_irq(8'h00);
        set_mask(8'h01);
        send_cmd(1'b0, 1'b0, 1'b1, 3'd0);
        set_mask(8'h00);
        set_irq(8'h02);
        chk(int_out == 1'b0, "R10 masked level 0 kept", int_out, 0);
        send_cmd(1'b0, 1'b1, 1'b1, 3'd0);
        set_irq(8'h20);
        chk(int_out == 1'b1, "R10 level 4 was cleared", int_out, 1);
        set_irq(8'h00);
        set_cfg(1'b0, 1'b0);
    endtask

    task automatic t_auto;
        logic [7:0] v;
        set_cfg(1'b1, 1'b0);
        set_irq(8'h40);
        do_ack(v);
        chk(v == 8'hAE, "R11 vector level 6", v, 8'hAE);
        @(negedge clk);
        chk(int_out == 1'b1, "R11 released after ack", int_out, 1);
        set_irq(8'h00);
        set_cfg(1'b0, 1'b0);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; mask_wr = 1'b0; mask_din = '0;
        base_wr = 1'b0; base_din = '0; cfg_wr = 1'b0; cfg_auto_eoi = 1'b0; cfg_smm = 1'b0;
        cmd_wr = 1'b0; cmd_eoi = 1'b0; cmd_sl = 1'b0; cmd_rot = 1'b0; cmd_lvl = '0;
        inta = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_raise_mask;
        t_ack_nest;
        t_no_request;
        t_nonspec;
        t_ignored;
        t_smm;
        t_auto;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule